// File: doc/BRIEF.md
# Co-processor Error Classifier and Alert Controller

This block sits beside the sequencer of a small cryptographic co-processor and decides what happens when something goes wrong. Each error cause arrives as a one-cycle pulse on its own bit of an input vector. A parameter mask splits the causes into two classes. Software-level causes are recoverable. Integrity-style causes are fatal. The block keeps its own running flag, which the host sets with a start command and the sequencer clears with a finish pulse. It produces the requests for the rest of the accelerator: halt execution, scrub internal state, and scrub both memories. It also drives the done event and two alert lines.

With a recoverable cause, the current operation ends cleanly. Execution halts, internal state is scrubbed, the cause is recorded in the error-bits register, and done is signalled. A one-shot alert follows one cycle later. The host may then start again.

A fatal cause can be seen at any time. It always requests a scrub of both memories, accumulates into a sticky fatal-cause register, and raises a level alert that only reset removes. If the core was running, the same termination sequence also runs. If the core was idle, the error-bits register is left alone. While a scrub is in progress, every cause is ignored.

Top module: `accel_err_ctrl`

## Requirements
- R1: After reset, every output is zero: running flag, request pulses, done, error bits, fatal-cause register and both alerts.
- R2: When idle and not locked, a start sets the running flag and clears the error bits on the next cycle. A finish while running clears the flag and pulses done for one cycle, without a halt or scrub request.
- R3: A recoverable cause (bits 0 to 4) seen while running produces the following on the next cycle: a one-cycle halt pulse, a one-cycle internal-scrub pulse and a one-cycle done pulse. The running flag drops and the error bits hold exactly the causes of that cycle.
- R4: A recoverable cause seen while running raises the recoverable alert as a single one-cycle pulse, two cycles after the cause.
- R5: A recoverable cause seen while idle has no effect on any output.
- R6: A fatal cause (bits 5 to 7) produces a one-cycle memory-scrub pulse on the next cycle, whether or not the core is running. It is ORed into the fatal-cause register, which never loses a bit before reset. It sets the fatal alert, which stays high until reset.
- R7: A fatal cause seen while running also runs the R3 termination sequence and writes the error bits. A recoverable cause in the same cycle still raises its own alert.
- R8: A fatal cause seen while idle leaves the error bits unchanged.
- R9: While the scrub-in-progress input is high, all causes are ignored.
- R10: Several causes in the same cycle are ORed into the registers.
- R11: Once the fatal alert is set, start commands are ignored and the running flag stays low.
- R12: A host clear zeroes the error bits. A termination in the same cycle takes priority and writes the new causes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Host command to begin an operation |
| finish_i | input | 1 | Normal end of program from the sequencer |
| err_i | input | 8 | Per-cause error pulses |
| wipe_active_i | input | 1 | A secure scrub is in progress |
| err_clr_i | input | 1 | Host write-to-clear of the error bits |
| busy_o | output | 1 | Operation running |
| stop_o | output | 1 | Halt fetch and execution (pulse) |
| wipe_int_o | output | 1 | Request internal-state scrub (pulse) |
| wipe_mem_o | output | 1 | Request scrub of both memories (pulse) |
| done_o | output | 1 | Operation complete event (pulse) |
| err_bits_o | output | 8 | Error-bits register |
| fatal_cause_o | output | 8 | Sticky fatal-cause register |
| alert_rec_o | output | 1 | Recoverable alert (one-shot) |
| alert_fatal_o | output | 1 | Fatal alert (level, held until reset) |

## Verification
The bench targets a fatal cause that arrives while the core is idle. A design that wrote the error bits there would corrupt what the host reads back, and one that ignored it would miss the memory scrub.

It also checks that the recoverable alert lags done by exactly one cycle and is never stretched, that a recoverable cause with no program running is dropped, and that a cause arriving during a scrub starts nothing new.

Two more orderings are exercised. A host clear coinciding with a termination must not erase the fresh cause. A start after a fatal event must not revive the core. A second reset phase confirms that the fatal alert persists across idle cycles and clears only on reset.

// File: rtl/accel_err_pkg.sv
package accel_err_pkg;
  localparam int unsigned CAUSE_W          = 8;
  localparam logic [CAUSE_W-1:0] FATAL_SET = 8'hE0;

  typedef struct packed {
    logic stop;
    logic wipe_int;
    logic done;
  } term_resp_t;
endpackage

// File: rtl/accel_err_classify.sv
module accel_err_classify #(
  parameter int unsigned CAUSE_W = 8,
  parameter logic [CAUSE_W-1:0] FATAL_SET = '0
) (
  input  logic [CAUSE_W-1:0] err_i,
  input  logic               wipe_active_i,
  input  logic               busy_i,
  output logic [CAUSE_W-1:0] det_o,
  output logic [CAUSE_W-1:0] fat_bits_o,
  output logic               rec_hit_o,
  output logic               fat_hit_o
);
  logic [CAUSE_W-1:0] rec_bits;

  // Per-cause classification; the scrub flag masks every cause.
  for (genvar i = 0; i < CAUSE_W; i++) begin : g_cause
    if (FATAL_SET[i]) begin : g_fatal
      assign fat_bits_o[i] = err_i[i] & ~wipe_active_i;
      assign rec_bits[i]   = 1'b0;
    end else begin : g_rec
      assign fat_bits_o[i] = 1'b0;
      assign rec_bits[i]   = err_i[i] & ~wipe_active_i & busy_i;
    end
  end

  assign det_o     = fat_bits_o | rec_bits;
  assign rec_hit_o = |rec_bits;
  assign fat_hit_o = |fat_bits_o;
endmodule

// File: rtl/accel_err_opctl.sv
module accel_err_opctl
  import accel_err_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start_i,
  input  logic       finish_i,
  input  logic       rec_hit_i,
  input  logic       fat_hit_i,
  input  logic       locked_i,
  output logic       busy_o,
  output logic       term_o,
  output logic       start_ok_o,
  output term_resp_t resp_o
);
  logic       busy_d, busy_q;
  term_resp_t resp_d, resp_q;
  logic       term;

  always_comb begin
    term       = busy_q & (rec_hit_i | fat_hit_i);
    start_ok_o = start_i & ~busy_q & ~locked_i & ~fat_hit_i;
    busy_d     = busy_q;
    if (term)                    busy_d = 1'b0;
    else if (busy_q && finish_i) busy_d = 1'b0;
    else if (start_ok_o)         busy_d = 1'b1;
    resp_d.stop     = term;
    resp_d.wipe_int = term;
    resp_d.done     = term | (busy_q & finish_i);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      resp_q <= '0;
    end else begin
      busy_q <= busy_d;
      resp_q <= resp_d;
    end
  end

  assign busy_o = busy_q;
  assign term_o = term;
  assign resp_o = resp_q;
endmodule

// File: rtl/accel_err_regs.sv
module accel_err_regs #(
  parameter int unsigned CAUSE_W = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               term_i,
  input  logic               start_ok_i,
  input  logic               clr_i,
  input  logic [CAUSE_W-1:0] det_i,
  input  logic [CAUSE_W-1:0] fat_bits_i,
  output logic [CAUSE_W-1:0] err_bits_o,
  output logic [CAUSE_W-1:0] fatal_cause_o
);
  logic [CAUSE_W-1:0] err_d, err_q, fc_d, fc_q;
  logic               err_en, fc_en;

  always_comb begin
    err_en = term_i | start_ok_i | clr_i;
    err_d  = term_i ? det_i : '0;
    fc_en  = |fat_bits_i;
    fc_d   = fc_q | fat_bits_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      err_q <= '0;
      fc_q  <= '0;
    end else begin
      if (err_en) err_q <= err_d;
      if (fc_en)  fc_q  <= fc_d;
    end
  end

  assign err_bits_o    = err_q;
  assign fatal_cause_o = fc_q;
endmodule

// File: rtl/accel_err_alert.sv
module accel_err_alert (
  input  logic clk,
  input  logic rst_n,
  input  logic rec_hit_i,
  input  logic fat_hit_i,
  output logic alert_rec_o,
  output logic alert_fatal_o,
  output logic wipe_mem_o
);
  logic rpend_q, ralert_q, flock_q, wmem_q;
  logic rpend_d, ralert_d, flock_d, wmem_d;

  always_comb begin
    rpend_d  = rec_hit_i;
    ralert_d = rpend_q;
    flock_d  = flock_q | fat_hit_i;
    wmem_d   = fat_hit_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rpend_q  <= 1'b0;
      ralert_q <= 1'b0;
      flock_q  <= 1'b0;
      wmem_q   <= 1'b0;
    end else begin
      rpend_q  <= rpend_d;
      ralert_q <= ralert_d;
      flock_q  <= flock_d;
      wmem_q   <= wmem_d;
    end
  end

  assign alert_rec_o   = ralert_q;
  assign alert_fatal_o = flock_q;
  assign wipe_mem_o    = wmem_q;
endmodule

// File: rtl/accel_err_ctrl.sv
module accel_err_ctrl
  import accel_err_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start_i,
  input  logic               finish_i,
  input  logic [CAUSE_W-1:0] err_i,
  input  logic               wipe_active_i,
  input  logic               err_clr_i,
  output logic               busy_o,
  output logic               stop_o,
  output logic               wipe_int_o,
  output logic               wipe_mem_o,
  output logic               done_o,
  output logic [CAUSE_W-1:0] err_bits_o,
  output logic [CAUSE_W-1:0] fatal_cause_o,
  output logic               alert_rec_o,
  output logic               alert_fatal_o
);
  logic               rst_s1_q, rst_s2_q, rst_int_n;
  logic [CAUSE_W-1:0] det, fat_bits;
  logic               rec_hit, fat_hit, term, start_ok, busy;
  term_resp_t         resp;

  // Assert asynchronously, release on a clock edge.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_s1_q <= 1'b0;
      rst_s2_q <= 1'b0;
    end else begin
      rst_s1_q <= 1'b1;
      rst_s2_q <= rst_s1_q;
    end
  end
  assign rst_int_n = rst_s2_q;

  accel_err_classify #(.CAUSE_W(CAUSE_W), .FATAL_SET(FATAL_SET)) u_cls (
    .err_i(err_i), .wipe_active_i(wipe_active_i), .busy_i(busy),
    .det_o(det), .fat_bits_o(fat_bits), .rec_hit_o(rec_hit), .fat_hit_o(fat_hit)
  );

  accel_err_opctl u_op (
    .clk(clk), .rst_n(rst_int_n), .start_i(start_i), .finish_i(finish_i),
    .rec_hit_i(rec_hit), .fat_hit_i(fat_hit), .locked_i(alert_fatal_o),
    .busy_o(busy), .term_o(term), .start_ok_o(start_ok), .resp_o(resp)
  );

  accel_err_regs #(.CAUSE_W(CAUSE_W)) u_regs (
    .clk(clk), .rst_n(rst_int_n), .term_i(term), .start_ok_i(start_ok),
    .clr_i(err_clr_i), .det_i(det), .fat_bits_i(fat_bits),
    .err_bits_o(err_bits_o), .fatal_cause_o(fatal_cause_o)
  );

  accel_err_alert u_alert (
    .clk(clk), .rst_n(rst_int_n), .rec_hit_i(rec_hit), .fat_hit_i(fat_hit),
    .alert_rec_o(alert_rec_o), .alert_fatal_o(alert_fatal_o), .wipe_mem_o(wipe_mem_o)
  );

  assign busy_o     = busy;
  assign stop_o     = resp.stop;
  assign wipe_int_o = resp.wipe_int;
  assign done_o     = resp.done;
endmodule

// File: rtl/accel_err_ctrl_chk.sv
module accel_err_ctrl_chk #(
  parameter int unsigned W = 8
) (
  input logic         clk,
  input logic         rst_n,
  input logic         start_i,
  input logic         err_clr_i,
  input logic         wipe_active_i,
  input logic         busy_o,
  input logic         done_o,
  input logic         wipe_mem_o,
  input logic         alert_rec_o,
  input logic         alert_fatal_o,
  input logic [W-1:0] err_bits_o,
  input logic [W-1:0] fatal_cause_o
);
  a_r6_fatal_alert_held: assert property (@(posedge clk) disable iff (!rst_n)
    alert_fatal_o |=> alert_fatal_o);

  a_r6_cause_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((fatal_cause_o & $past(fatal_cause_o)) == $past(fatal_cause_o)));

  a_r4_rec_one_shot: assert property (@(posedge clk) disable iff (!rst_n)
    alert_rec_o |=> !alert_rec_o);

  a_r3_done_not_busy: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> !busy_o);

  a_r11_locked_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (alert_fatal_o && !busy_o) |=> !busy_o);

  a_r9_wipe_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    wipe_active_i |=> !wipe_mem_o);

  a_r8_idle_bits_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_o && !start_i && !err_clr_i) |=> $stable(err_bits_o));
endmodule

bind accel_err_ctrl accel_err_ctrl_chk #(.W(accel_err_pkg::CAUSE_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .start_i(start_i), .err_clr_i(err_clr_i),
  .wipe_active_i(wipe_active_i), .busy_o(busy_o), .done_o(done_o),
  .wipe_mem_o(wipe_mem_o), .alert_rec_o(alert_rec_o), .alert_fatal_o(alert_fatal_o),
  .err_bits_o(err_bits_o), .fatal_cause_o(fatal_cause_o)
);

// File: tb/accel_err_ctrl_test.sv
module accel_err_ctrl_test;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       start_i, finish_i, wipe_active_i, err_clr_i;
  logic [7:0] err_i;
  logic       busy_o, stop_o, wipe_int_o, wipe_mem_o, done_o, alert_rec_o, alert_fatal_o;
  logic [7:0] err_bits_o, fatal_cause_o;

  int    vectors = 0;
  int    fails   = 0;
  int    cycles  = 0;
  string cur_req = "R1";

  // Reference state
  bit       m_busy, m_lock, m_stop, m_wint, m_wmem, m_done, m_rpend, m_ralert;
  bit [7:0] m_err, m_fc;
  localparam bit [7:0] FMASK = 8'hE0;

  always #10 clk = ~clk;

  accel_err_ctrl uut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .finish_i(finish_i),
    .err_i(err_i), .wipe_active_i(wipe_active_i), .err_clr_i(err_clr_i),
    .busy_o(busy_o), .stop_o(stop_o), .wipe_int_o(wipe_int_o),
    .wipe_mem_o(wipe_mem_o), .done_o(done_o), .err_bits_o(err_bits_o),
    .fatal_cause_o(fatal_cause_o), .alert_rec_o(alert_rec_o),
    .alert_fatal_o(alert_fatal_o)
  );

  task automatic finish_run();
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 5000) begin
      fails++;
      $display("FAIL watchdog: actual cycles=%0d expected < 5000", cycles);
      finish_run();
    end
  end

  task automatic model_reset();
    m_busy = 0; m_lock = 0; m_stop = 0; m_wint = 0; m_wmem = 0;
    m_done = 0; m_rpend = 0; m_ralert = 0; m_err = 0; m_fc = 0;
  endtask

  task automatic chk1(string nm, logic a, bit e);
    if (a !== e) begin
      fails++;
      $display("FAIL %s %s: actual=%b expected=%b", cur_req, nm, a, e);
    end
  endtask

  task automatic chk8(string nm, logic [7:0] a, bit [7:0] e);
    if (a !== e) begin
      fails++;
      $display("FAIL %s %s: actual=%h expected=%h", cur_req, nm, a, e);
    end
  endtask

  task automatic compare();
    vectors++;
    chk1("busy", busy_o, m_busy);
    chk1("stop", stop_o, m_stop);
    chk1("wipe_int", wipe_int_o, m_wint);
    chk1("wipe_mem", wipe_mem_o, m_wmem);
    chk1("done", done_o, m_done);
    chk1("alert_rec", alert_rec_o, m_ralert);
    chk1("alert_fatal", alert_fatal_o, m_lock);
    chk8("err_bits", err_bits_o, m_err);
    chk8("fatal_cause", fatal_cause_o, m_fc);
  endtask

  // One clock: drive at negedge, advance the model, compare after the edge.
  task automatic step(bit st = 0, bit fin = 0, bit [7:0] e = 0, bit wp = 0, bit clr = 0);
    bit [7:0] det;
    bit rec, fat, term, sok;
    @(negedge clk);
    start_i = st; finish_i = fin; err_i = e; wipe_active_i = wp; err_clr_i = clr;
    det  = wp ? 8'h00 : (e & (m_busy ? 8'hFF : FMASK));
    rec  = |(det & ~FMASK);
    fat  = |(det & FMASK);
    term = m_busy && (rec || fat);
    sok  = st && !m_busy && !m_lock && !fat;
    m_stop = term; m_wint = term;
    m_done = term || (m_busy && fin);
    m_wmem = fat;
    m_ralert = m_rpend; m_rpend = rec;
    m_fc = m_fc | (det & FMASK);
    if (term) m_err = det; else if (sok || clr) m_err = 0;
    if (term) m_busy = 0; else if (m_busy && fin) m_busy = 0; else if (sok) m_busy = 1;
    m_lock = m_lock || fat;
    @(posedge clk); #2;
    compare();
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 0; start_i = 0; finish_i = 0; err_i = 0; wipe_active_i = 0; err_clr_i = 0;
    model_reset();
    repeat (3) @(negedge clk);
    cur_req = "R1";
    compare();
    rst_n = 1;
    repeat (4) step();
  endtask

  initial begin
    rst_n = 0; start_i = 0; finish_i = 0; err_i = 0; wipe_active_i = 0; err_clr_i = 0;
    model_reset();
    do_reset();

    cur_req = "R2";  step(1); repeat (2) step(); step(0, 1); step(); step();
    cur_req = "R5";  step(0, 0, 8'h01); step(0, 0, 8'h10); repeat (3) step();
    cur_req = "R3";  step(1); step(0, 0, 8'h04); step(); step(); step();
    cur_req = "R4";  step(1); step(0, 0, 8'h08); repeat (4) step();
    cur_req = "R12"; step(0, 0, 0, 0, 1); step();
    cur_req = "R10"; step(1); step(0, 0, 8'h09); repeat (3) step();
    cur_req = "R12"; step(1); step(0, 0, 8'h02, 0, 1); repeat (3) step();
    cur_req = "R9";  step(1); step(0, 0, 8'h42, 1); step(0, 0, 8'h80, 1); step(); step(0, 1); step();
    cur_req = "R2";  step(1); step(1); step(0, 1); step();
    cur_req = "R7";  step(1); step(0, 0, 8'h41); repeat (4) step();
    cur_req = "R11"; step(1); repeat (2) step();
    cur_req = "R6";  repeat (6) step();
    do_reset();
    cur_req = "R8";  step(1); step(0, 0, 8'h10); step(); step();
    step(0, 0, 8'h20); repeat (3) step();
    cur_req = "R11"; step(1); step(1); repeat (2) step();
    cur_req = "R6";  step(0, 0, 8'h80); step(0, 0, 8'h20); repeat (5) step();
    do_reset();
    cur_req = "R1";  repeat (3) step();

    finish_run();
  end
endmodule